// File: doc/BRIEF.md
# Dual-Alignment PWM Channel

This block is one pulse-width modulation channel. It holds a 16-bit counter that advances only on a count strobe picked from a bank of strobes. Eleven of these strobes come from power-of-two prescalers of the system clock (divide by 1 through 1024). Two more come from programmable dividers, A and B. The shared generator that makes these strobes lives outside the block and is seen here only as input pulses. A comparator turns the counter value and a duty setting into the output waveform.

There are two alignment modes. In left-aligned mode the counter climbs and wraps, so one output period takes `period` count strobes. In center-aligned mode it climbs to `period` and then falls back to 0, so one output period takes twice as many strobes. Period, duty and alignment are copied into shadow registers only when a period ends, so a change written mid-period cannot cut a pulse short. Polarity is applied directly.

A three-state machine controls the counter:
- `ST_IDLE`: the channel is disabled.
  - `ST_IDLE -> ST_UP` when the enable rises. The shadows are loaded on this transition.
- `ST_UP`: the counter climbs.
  - `ST_UP -> ST_UP` on a left-aligned wrap, or on a center-aligned period of 0. Both are period ends.
  - `ST_UP -> ST_DOWN` when a center-aligned count reaches `period`.
- `ST_DOWN`: the counter falls.
  - `ST_DOWN -> ST_UP` when the count reaches 0. This is a period end.
- `any -> ST_IDLE` whenever the enable is low.

Top module: `pwm_dual_channel`

## Requirements
- R1: While `chan_en` is low, and after reset, the counter reads 0, `period_evt` is 0 and `pwm_out` equals `cfg_invert` (the inactive level). The cycle after `chan_en` rises, the counter is 0 and the shadows hold the configuration inputs.
- R2: `cfg_clk_sel` values 0 to 10 pick `tick_pow2[sel]` (divide by 2^sel). Value 11 picks `tick_div_a` and value 12 picks `tick_div_b`. Values 13 to 15 pick no strobe. The counter changes only on an edge where the selected strobe is high.
- R3: In left-aligned mode (`cfg_center`=0) with shadow period P ≥ 1, the counter steps 0,1,…,P−1 and then 0. `period_evt` is high for exactly the cycle after the wrap edge, so events come P × divide-ratio cycles apart.
- R4: In center-aligned mode (`cfg_center`=1) with P ≥ 1, the counter steps 0 up to P, then down to 0. `period_evt` pulses when 0 is reached, so events come 2 × P × divide-ratio cycles apart.
- R5: `pwm_out` = active XOR `cfg_invert`, where active is 1 when duty ≠ 0 and (count < duty or duty ≥ P). A duty of 0 gives a constant inactive level. A duty ≥ P gives a constant active level.
- R6: The shadow period, duty and alignment change only at a period event or on leaving idle. New values written mid-period take effect from the next period.
- R7: A shadow period of 0 (either mode), or of 1 (left-aligned), keeps the counter at 0 and raises `period_evt` after every selected strobe.
- R8: A change of alignment takes effect at the next period event, and the new mode starts from count 0 while climbing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable |
| tick_pow2 | input | 11 | Prescaler strobes, bit i pulses every 2^i cycles |
| tick_div_a | input | 1 | Divider A strobe |
| tick_div_b | input | 1 | Divider B strobe |
| cfg_clk_sel | input | 4 | Count-strobe select |
| cfg_center | input | 1 | 1 = center-aligned, 0 = left-aligned |
| cfg_invert | input | 1 | Output polarity: inactive level |
| cfg_period | input | 16 | Period value |
| cfg_duty | input | 16 | Duty value |
| cnt_value | output | 16 | Current counter value |
| period_evt | output | 1 | One-cycle period-end pulse |
| pwm_out | output | 1 | PWM waveform |

## Verification
A corrupted counter or a wrong up/down state shows at `cnt_value` at the next selected strobe. It also shifts the spacing of `period_evt`, which betrays the fault within one output period. A shadow register reloaded at the wrong time shows as a pulse width or event spacing from the wrong configuration during the period in which the change is written. The bench catches this by comparing every cycle against an independent model. A stuck state register drives `pwm_out` to the inactive level, which shows in the per-period count of active cycles.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
    localparam int CNT_W  = 16;
    localparam int N_POW2 = 11;
    localparam int SEL_W  = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_UP   = 2'd1,
        ST_DOWN = 2'd2
    } cnt_state_e;
endpackage

// File: rtl/pwm_clk_select.sv
module pwm_clk_select #(
    parameter int N_POW2 = pwm_chan_pkg::N_POW2,
    parameter int SEL_W  = pwm_chan_pkg::SEL_W
) (
    input  logic [N_POW2-1:0] tick_pow2,
    input  logic              tick_div_a,
    input  logic              tick_div_b,
    input  logic [SEL_W-1:0]  sel,
    output logic              sel_tick
);
    localparam int N_SRC = 1 << SEL_W;

    logic [N_SRC-1:0] src;

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        if (g < N_POW2) begin : g_pow
            assign src[g] = tick_pow2[g];
        end else if (g == N_POW2) begin : g_a
            assign src[g] = tick_div_a;
        end else if (g == N_POW2 + 1) begin : g_b
            assign src[g] = tick_div_b;
        end else begin : g_none
            assign src[g] = 1'b0;
        end
    end

    assign sel_tick = src[sel];
endmodule

// File: rtl/pwm_count_fsm.sv
module pwm_count_fsm
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W = pwm_chan_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_en,
    input  logic             tick,
    input  logic             cfg_center,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [CNT_W-1:0] cfg_duty,
    output logic [CNT_W-1:0] cnt,
    output logic             period_evt,
    output logic [CNT_W-1:0] per_sh,
    output logic [CNT_W-1:0] duty_sh,
    output logic             in_idle
);
    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             evt_q, evt_d;
    logic             ctr_sh;
    logic             load;
    logic [CNT_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + 1'b1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            evt_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            evt_q   <= evt_d;
        end
    end

    // shadow configuration, loaded at period boundaries only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_sh  <= '0;
            duty_sh <= '0;
            ctr_sh  <= 1'b0;
        end else if (load) begin
            per_sh  <= cfg_period;
            duty_sh <= cfg_duty;
            ctr_sh  <= cfg_center;
        end
    end

    // next state and counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        evt_d   = 1'b0;
        load    = 1'b0;
        if (!chan_en) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_UP;
                    cnt_d   = '0;
                    load    = 1'b1;
                end
                ST_UP: begin
                    if (tick) begin
                        if (!ctr_sh) begin
                            if (cnt_inc >= {1'b0, per_sh}) begin
                                cnt_d = '0;
                                evt_d = 1'b1;
                                load  = 1'b1;
                            end else begin
                                cnt_d = cnt_inc[CNT_W-1:0];
                            end
                        end else if (cnt_q >= per_sh) begin
                            cnt_d = '0;
                            evt_d = 1'b1;
                            load  = 1'b1;
                        end else begin
                            cnt_d = cnt_inc[CNT_W-1:0];
                            if (cnt_inc == {1'b0, per_sh}) begin
                                state_d = ST_DOWN;
                            end
                        end
                    end
                end
                ST_DOWN: begin
                    if (tick) begin
                        cnt_d = cnt_q - 1'b1;
                        if (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1}) begin
                            state_d = ST_UP;
                            evt_d   = 1'b1;
                            load    = 1'b1;
                        end
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        cnt        = cnt_q;
        period_evt = evt_q;
        in_idle    = (state_q == ST_IDLE);
    end
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
    parameter int CNT_W = pwm_chan_pkg::CNT_W
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] per_sh,
    input  logic [CNT_W-1:0] duty_sh,
    input  logic             in_idle,
    input  logic             invert,
    output logic             pwm_out
);
    logic active;

    always_comb begin
        if (in_idle || duty_sh == '0) begin
            active = 1'b0;
        end else begin
            active = (duty_sh >= per_sh) || (cnt < duty_sh);
        end
        pwm_out = active ^ invert;
    end
endmodule

// File: rtl/pwm_dual_channel.sv
module pwm_dual_channel
    import pwm_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_en,
    input  logic [N_POW2-1:0] tick_pow2,
    input  logic              tick_div_a,
    input  logic              tick_div_b,
    input  logic [SEL_W-1:0]  cfg_clk_sel,
    input  logic              cfg_center,
    input  logic              cfg_invert,
    input  logic [CNT_W-1:0]  cfg_period,
    input  logic [CNT_W-1:0]  cfg_duty,
    output logic [CNT_W-1:0]  cnt_value,
    output logic              period_evt,
    output logic              pwm_out
);
    logic             sel_tick;
    logic [CNT_W-1:0] per_sh;
    logic [CNT_W-1:0] duty_sh;
    logic             in_idle;

    pwm_clk_select #(.N_POW2(N_POW2), .SEL_W(SEL_W)) u_sel (
        .tick_pow2  (tick_pow2),
        .tick_div_a (tick_div_a),
        .tick_div_b (tick_div_b),
        .sel        (cfg_clk_sel),
        .sel_tick   (sel_tick)
    );

    pwm_count_fsm #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_en    (chan_en),
        .tick       (sel_tick),
        .cfg_center (cfg_center),
        .cfg_period (cfg_period),
        .cfg_duty   (cfg_duty),
        .cnt        (cnt_value),
        .period_evt (period_evt),
        .per_sh     (per_sh),
        .duty_sh    (duty_sh),
        .in_idle    (in_idle)
    );

    pwm_compare #(.CNT_W(CNT_W)) u_cmp (
        .cnt     (cnt_value),
        .per_sh  (per_sh),
        .duty_sh (duty_sh),
        .in_idle (in_idle),
        .invert  (cfg_invert),
        .pwm_out (pwm_out)
    );
endmodule

// File: rtl/pwm_dual_channel_chk.sv
module pwm_dual_channel_chk #(
    parameter int CNT_W = pwm_chan_pkg::CNT_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             chan_en,
    input logic             sel_tick,
    input logic [CNT_W-1:0] cnt_value,
    input logic             period_evt,
    input logic             pwm_out,
    input logic             cfg_invert,
    input logic [CNT_W-1:0] per_sh,
    input logic [CNT_W-1:0] duty_sh,
    input logic             in_idle
);
    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> (cnt_value == '0) && !period_evt); // R1

    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && !sel_tick) |=> $stable(cnt_value)); // R2

    AST_EVT_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        period_evt |-> (cnt_value == '0)); // R3

    AST_EVT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_tick |=> !period_evt); // R3

    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_value <= per_sh) || (cnt_value == '0)); // R4

    AST_DUTY_ZERO_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_sh == '0) |-> (pwm_out == cfg_invert)); // R5

    AST_SHADOW_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (per_sh != $past(per_sh) || duty_sh != $past(duty_sh))
            |-> (period_evt || $past(in_idle))); // R6
endmodule

bind pwm_dual_channel pwm_dual_channel_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chan_en    (chan_en),
    .sel_tick   (sel_tick),
    .cnt_value  (cnt_value),
    .period_evt (period_evt),
    .pwm_out    (pwm_out),
    .cfg_invert (cfg_invert),
    .per_sh     (per_sh),
    .duty_sh    (duty_sh),
    .in_idle    (in_idle)
);

// File: tb/tb_pwm_dual_channel.sv
`timescale 1ns/1ps
module tb_pwm_dual_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_en = 1'b0;
    logic [10:0] tick_pow2 = '0;
    logic        tick_div_a = 1'b0;
    logic        tick_div_b = 1'b0;
    logic [3:0]  cfg_clk_sel = '0;
    logic        cfg_center = 1'b0;
    logic        cfg_invert = 1'b1;
    logic [15:0] cfg_period = 16'd5;
    logic [15:0] cfg_duty = 16'd2;
    logic [15:0] cnt_value;
    logic        period_evt;
    logic        pwm_out;

    always #4 clk = ~clk;

    pwm_dual_channel dut (
        .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .tick_pow2(tick_pow2),
        .tick_div_a(tick_div_a), .tick_div_b(tick_div_b), .cfg_clk_sel(cfg_clk_sel),
        .cfg_center(cfg_center), .cfg_invert(cfg_invert), .cfg_period(cfg_period),
        .cfg_duty(cfg_duty), .cnt_value(cnt_value), .period_evt(period_evt),
        .pwm_out(pwm_out)
    );

    typedef struct {
        int    cnt;
        bit    evt;
        bit    out;
        string tag;
    } exp_t;

    exp_t sb_q[$];
    int checks = 0;
    int failures = 0;
    int mclk = 0;
    int cyc = 0;
    int last_evt_cyc = -1;
    int last_gap = 0;
    int hi_cycles = 0;
    int max_cnt = 0;

    // reference model state
    bit m_idle = 1;
    bit m_up = 1;
    bit m_ctr = 0;
    int m_cnt = 0;
    int m_per = 0;
    int m_duty = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    task automatic m_reload();
        m_per = int'(cfg_period);
        m_duty = int'(cfg_duty);
        m_ctr = cfg_center;
        m_up = 1;
    endtask

    // driver: apply one cycle of strobes, predict, push expectation
    task automatic step();
        bit tk;
        bit evt;
        bit act;
        exp_t e;
        mclk++;
        for (int i = 0; i < 11; i++) tick_pow2[i] = ((mclk % (1 << i)) == 0);
        tick_div_a = ((mclk % 3) == 0);
        tick_div_b = ((mclk % 5) == 0);
        if (cfg_clk_sel <= 4'd10) tk = tick_pow2[cfg_clk_sel];
        else if (cfg_clk_sel == 4'd11) tk = tick_div_a;
        else if (cfg_clk_sel == 4'd12) tk = tick_div_b;
        else tk = 0;
        evt = 0;
        if (!chan_en) begin
            m_idle = 1; m_cnt = 0;
        end else if (m_idle) begin
            m_idle = 0; m_cnt = 0; m_reload();
        end else if (tk) begin
            if (!m_ctr) begin
                if (m_cnt + 1 >= m_per) begin m_cnt = 0; evt = 1; m_reload(); end
                else m_cnt++;
            end else if (m_up) begin
                if (m_cnt >= m_per) begin m_cnt = 0; evt = 1; m_reload(); end
                else begin m_cnt++; if (m_cnt == m_per) m_up = 0; end
            end else begin
                m_cnt--;
                if (m_cnt == 0) begin evt = 1; m_reload(); end
            end
        end
        act = !m_idle && (m_duty != 0) && ((m_duty >= m_per) || (m_cnt < m_duty));
        e.cnt = m_cnt;
        e.evt = evt;
        e.out = act ^ cfg_invert;
        e.tag = m_idle ? "R1" : (m_ctr ? "R4" : "R3");
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic run(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    // monitor: compare after each edge
    always @(posedge clk) begin
        exp_t e;
        #1;
        cyc++;
        if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            check(cnt_value == e.cnt[15:0], {e.tag, " count"}, int'(cnt_value), e.cnt);
            check(period_evt == e.evt, {e.tag, " event"}, int'(period_evt), int'(e.evt));
            check(pwm_out == e.out, "R5 output", int'(pwm_out), int'(e.out));
        end
        if (period_evt) begin
            if (last_evt_cyc >= 0) last_gap = cyc - last_evt_cyc;
            last_evt_cyc = cyc;
        end
        if (pwm_out != cfg_invert) hi_cycles++;
        if (int'(cnt_value) > max_cnt) max_cnt = int'(cnt_value);
    end

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int held;
        repeat (4) @(negedge clk);
        // R1: reset state, inactive level follows polarity
        check(cnt_value == 16'd0, "R1 reset count", int'(cnt_value), 0);
        check(period_evt == 1'b0, "R1 reset event", int'(period_evt), 0);
        check(pwm_out == 1'b1, "R1 reset inactive level", int'(pwm_out), 1);
        rst_n = 1'b1;
        run(3);
        check(pwm_out == 1'b1, "R1 disabled inactive", int'(pwm_out), 1);

        // R3 left aligned, undivided
        cfg_invert = 1'b0;
        chan_en = 1'b1;
        run(20);
        check(last_gap == 5, "R3 left period sel0", last_gap, 5);
        hi_cycles = 0; run(10);
        check(hi_cycles == 4, "R5 left duty 2/5 active cycles", hi_cycles, 4);

        // R2 divide by 4
        cfg_clk_sel = 4'd2; cfg_period = 16'd4; cfg_duty = 16'd1;
        run(60);
        check(last_gap == 16, "R2 R3 left period div4", last_gap, 16);

        // R4 center aligned, inverted polarity
        cfg_clk_sel = 4'd0; cfg_center = 1'b1; cfg_period = 16'd4; cfg_duty = 16'd2;
        cfg_invert = 1'b1;
        run(40);
        check(last_gap == 8, "R4 R8 center period sel0", last_gap, 8);
        hi_cycles = 0; run(16);
        check(hi_cycles == 6, "R5 center duty active cycles", hi_cycles, 6);

        // R2 divider A and B in center mode
        cfg_clk_sel = 4'd11; cfg_period = 16'd3;
        run(80);
        check(last_gap == 18, "R2 R4 center period divA", last_gap, 18);
        cfg_clk_sel = 4'd12; cfg_center = 1'b0; cfg_period = 16'd4;
        run(80);
        check(last_gap == 20, "R2 R8 left period divB", last_gap, 20);

        // R2 unused select: frozen counter
        cfg_clk_sel = 4'd14;
        run(2);
        held = int'(cnt_value);
        run(25);
        check(int'(cnt_value) == held, "R2 unused select holds", int'(cnt_value), held);

        // R5 duty extremes
        cfg_clk_sel = 4'd0; cfg_period = 16'd5; cfg_duty = 16'd0; cfg_invert = 1'b0;
        run(20);
        hi_cycles = 0; run(10);
        check(hi_cycles == 0, "R5 duty zero inactive", hi_cycles, 0);
        cfg_duty = 16'd7;
        run(15);
        hi_cycles = 0; run(10);
        check(hi_cycles == 10, "R5 duty above period active", hi_cycles, 10);

        // R6 mid-period change waits for the boundary
        cfg_period = 16'd10; cfg_duty = 16'd3;
        run(30);
        held = 0;
        for (int k = 0; k < 12 && held == 0; k++) begin
            step();
            if (cnt_value == 16'd2) held = 1;
        end
        cfg_period = 16'd6;
        max_cnt = 0;
        run(8);
        check(max_cnt == 9, "R6 old period kept until event", max_cnt, 9);
        run(20);
        check(last_gap == 6, "R6 new period after event", last_gap, 6);

        // R7 degenerate periods
        cfg_period = 16'd1;
        run(15);
        check(last_gap == 1, "R7 left period one", last_gap, 1);
        cfg_center = 1'b1; cfg_period = 16'd0;
        run(10);
        check(last_gap == 1 && cnt_value == 16'd0, "R7 center period zero", last_gap, 1);

        // R1 disable mid-run
        cfg_period = 16'd6; cfg_duty = 16'd3; cfg_invert = 1'b1;
        run(20);
        chan_en = 1'b0;
        run(2);
        check(cnt_value == 16'd0 && pwm_out == 1'b1, "R1 disable clears", int'(cnt_value), 0);

        run(1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule